// File: doc/BRIEF.md
# ULPI PHY Serial-Mode Pin Multiplexer

This block sits on the PHY side of an 8-bit ULPI data bus. It gives the bus pins other jobs when the link asks for one of three alternate pin maps: a six-wire full/low-speed serial map, a three-wire full/low-speed serial map, and a low-power map. A register write from the link selects a map. The link leaves any of these maps by raising STP. While the bus is in the normal map, the block drives no bus pin, so the packet-mode logic (outside this block) owns turnaround.

In the alternate maps the block takes transmit enable, transmit data and single-ended-zero requests from the link-driven pins and sends them to the line side. It returns single-ended and differential receive levels on the pins the PHY drives. It also keeps a sticky interrupt flag, set by any event that its mask bit does not block, and shows that flag on DATA3. A clock-run output reports whether the PHY clock keeps running while a map is active. This depends on the clock-keep bit held before entry. The block has no streaming data path, so every pin is a plain level or a one-cycle strobe, with no valid/ready handshake and no back-pressure.

Top module: `ulpi_serial_mux`

## Requirements
- R1: After reset the block is in the normal map: `bus_oe` and `bus_out` are all zero, the three `line_tx_*` outputs are low, the interrupt flag is clear and `clk_run` is 1.
- R2: A `cfg_wr` strobe in the normal map selects a new map one cycle later, by priority: `cfg_six` selects the six-wire map, else `cfg_three` selects the three-wire map, else `cfg_sleep` selects the low-power map. With none of the three set, the map stays normal.
- R3: Six-wire map: DATA0/1/2 are inputs, read as transmit enable, transmit data and SE0. DATA3..DATA7 are driven: DATA3 = interrupt flag, DATA4 = `line_rx_dp`, DATA5 = `line_rx_dm`, DATA6 = `line_rx_rcv`, DATA7 = 0. `bus_oe` = 8'hF8 and does not change while the map is held.
- R4: Three-wire map: DATA0 is the transmit enable input. When DATA0 is 1, DATA1/2 are inputs (transmit data, SE0) and `bus_oe` = 8'hF8. When DATA0 is 0, the PHY drives DATA1 = `line_rx_rcv` and DATA2 = receive SE0 (1 when both `line_rx_dp` and `line_rx_dm` are 0), and `bus_oe` = 8'hFE. DATA3 = interrupt flag; DATA7..DATA4 are driven 0.
- R5: Low-power map: `bus_oe` = 8'hFF, DATA3 = interrupt flag and every other pin is driven 0.
- R6: STP high in any non-normal map returns the block to the normal map on the next cycle and clears the interrupt flag. STP in the normal map has no effect.
- R7: A `cfg_wr` strobe while a non-normal map is active is ignored.
- R8: The interrupt flag sets one cycle after any `irq_evt` bit whose `irq_mask` bit is 0 is high. A mask bit of 1 blocks its event. The flag holds until `irq_clr` or an STP exit clears it; a same-cycle event wins over a clear.
- R9: Each `cfg_wr` in the normal map loads the clock-keep bit from `cfg_clk_keep`. On entry to a map, `clk_run` becomes the clock-keep value held before that write. `clk_run` is 1 in the normal map.
- R10: `line_tx_en` follows DATA0 in both serial maps. `line_tx_dat` and `line_tx_se0` follow DATA1 and DATA2 only while `line_tx_en` is 1 and are 0 otherwise (and 0 in the normal and low-power maps).
- R11: In the normal map `bus_oe` is 0 and `bus_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Interface-control register write strobe |
| cfg_six | input | 1 | Write data: six-wire serial select |
| cfg_three | input | 1 | Write data: three-wire serial select |
| cfg_sleep | input | 1 | Write data: low-power select |
| cfg_clk_keep | input | 1 | Write data: keep clock running in alternate maps |
| stp | input | 1 | Link STP, exits any alternate map |
| bus_in | input | 8 | Data bus as seen by the PHY |
| bus_out | output | 8 | Data bus values driven by the PHY |
| bus_oe | output | 8 | Per-pin PHY output enable |
| line_tx_en | output | 1 | Line transmit enable |
| line_tx_dat | output | 1 | Line differential transmit data |
| line_tx_se0 | output | 1 | Line transmit single-ended zero |
| line_rx_dp | input | 1 | Single-ended receive from DP |
| line_rx_dm | input | 1 | Single-ended receive from DM |
| line_rx_rcv | input | 1 | Differential receive |
| irq_evt | input | EVT_W | Interrupt event pulses |
| irq_mask | input | EVT_W | Per-event mask, 1 blocks |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| clk_run | output | 1 | PHY clock keeps running |

## Verification
The hardest state to reach from the ports is a set interrupt flag seen together with an STP exit or a clear strobe in the same cycle. The flag is only visible on DATA3 while an alternate map is active. To get there, the stimulus first enters the six-wire map, raises an unmasked event, and only then applies the clear or STP. It then re-enters a map to check whether the flag survived. The clock-run rule needs a similar ordered sequence: one write sets the keep bit while the block is still in the normal map, and a separate later write selects the map.

// File: rtl/ulpi_sm_pkg.sv
package ulpi_sm_pkg;

  localparam int BUS_W = 8;

  // pin indices whose positions are fixed by the link-side decode
  localparam int PIN_TXEN  = 0;
  localparam int PIN_TXDAT = 1;
  localparam int PIN_TXSE0 = 2;
  localparam int PIN_IRQ   = 3;
  localparam int PIN_RXDP  = 4;
  localparam int PIN_RXDM  = 5;
  localparam int PIN_RXRCV = 6;
  localparam int PIN_S3RCV = 1;
  localparam int PIN_S3SE0 = 2;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SER6   = 2'd1,
    MODE_SER3   = 2'd2,
    MODE_LOWPWR = 2'd3
  } sm_mode_e;

  // output-enable mask: every pin from first_pin upward is PHY-driven
  function automatic logic [BUS_W-1:0] oe_from(input int first_pin);
    logic [BUS_W-1:0] m;
    for (int i = 0; i < BUS_W; i++) m[i] = (i >= first_pin);
    return m;
  endfunction

endpackage

// File: rtl/ulpi_sm_mode_ctrl.sv
module ulpi_sm_mode_ctrl
  import ulpi_sm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_wr,
  input  logic     cfg_six,
  input  logic     cfg_three,
  input  logic     cfg_sleep,
  input  logic     cfg_clk_keep,
  input  logic     stp,
  output sm_mode_e mode_q,
  output logic     exit_evt,
  output logic     clk_run
);

  sm_mode_e mode_d;
  logic     keep_q;
  logic     run_q;
  logic     wr_ok;

  assign wr_ok    = cfg_wr && (mode_q == MODE_NORMAL);
  assign exit_evt = stp && (mode_q != MODE_NORMAL);

  always_comb begin
    mode_d = mode_q;
    if (exit_evt) begin
      mode_d = MODE_NORMAL;
    end else if (wr_ok) begin
      if (cfg_six)        mode_d = MODE_SER6;
      else if (cfg_three) mode_d = MODE_SER3;
      else if (cfg_sleep) mode_d = MODE_LOWPWR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      keep_q <= 1'b1;
      run_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      if (wr_ok) keep_q <= cfg_clk_keep;
      if (wr_ok && (mode_d != MODE_NORMAL)) run_q <= keep_q;
    end
  end

  assign clk_run = (mode_q == MODE_NORMAL) ? 1'b1 : run_q;

endmodule

// File: rtl/ulpi_sm_irq_latch.sv
module ulpi_sm_irq_latch #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic [EVT_W-1:0] mask,
  input  logic             clr,
  input  logic             flush,
  output logic             irq_q
);

  logic [EVT_W-1:0] live;
  logic             hit;

  for (genvar g = 0; g < EVT_W; g++) begin : g_gate
    assign live[g] = evt[g] & ~mask[g];
  end

  assign hit = |live;

  always_ff @(posedge clk) begin
    if (!rst_n)            irq_q <= 1'b0;
    else if (hit)          irq_q <= 1'b1;
    else if (clr || flush) irq_q <= 1'b0;
  end

endmodule

// File: rtl/ulpi_sm_pin_map.sv
module ulpi_sm_pin_map
  import ulpi_sm_pkg::*;
(
  input  sm_mode_e         mode,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             irq,
  input  logic             rx_dp,
  input  logic             rx_dm,
  input  logic             rx_rcv,
  output logic [BUS_W-1:0] bus_out,
  output logic [BUS_W-1:0] bus_oe,
  output logic             tx_en,
  output logic             tx_dat,
  output logic             tx_se0
);

  localparam logic [BUS_W-1:0] OE_SER   = oe_from(PIN_IRQ);
  localparam logic [BUS_W-1:0] OE_S3RX  = oe_from(PIN_S3RCV);
  localparam logic [BUS_W-1:0] OE_ALL   = oe_from(0);

  logic [BUS_W-1:0] drv;
  logic             dat_raw;
  logic             se0_raw;

  always_comb begin
    drv     = '0;
    bus_oe  = '0;
    tx_en   = 1'b0;
    dat_raw = 1'b0;
    se0_raw = 1'b0;
    unique case (mode)
      MODE_SER6: begin
        bus_oe         = OE_SER;
        drv[PIN_IRQ]   = irq;
        drv[PIN_RXDP]  = rx_dp;
        drv[PIN_RXDM]  = rx_dm;
        drv[PIN_RXRCV] = rx_rcv;
        tx_en          = bus_in[PIN_TXEN];
        dat_raw        = bus_in[PIN_TXDAT];
        se0_raw        = bus_in[PIN_TXSE0];
      end
      MODE_SER3: begin
        tx_en          = bus_in[PIN_TXEN];
        bus_oe         = tx_en ? OE_SER : OE_S3RX;
        drv[PIN_S3RCV] = rx_rcv;
        drv[PIN_S3SE0] = ~rx_dp & ~rx_dm;
        drv[PIN_IRQ]   = irq;
        dat_raw        = bus_in[PIN_TXDAT];
        se0_raw        = bus_in[PIN_TXSE0];
      end
      MODE_LOWPWR: begin
        bus_oe       = OE_ALL;
        drv[PIN_IRQ] = irq;
      end
      default: ;
    endcase
  end

  // a pin shows a value only while the PHY owns it; reserved pins drive 0
  for (genvar b = 0; b < BUS_W; b++) begin : g_pin
    assign bus_out[b] = drv[b] & bus_oe[b];
  end

  assign tx_dat = tx_en & dat_raw;
  assign tx_se0 = tx_en & se0_raw;

endmodule

// File: rtl/ulpi_serial_mux.sv
module ulpi_serial_mux
  import ulpi_sm_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_six,
  input  logic             cfg_three,
  input  logic             cfg_sleep,
  input  logic             cfg_clk_keep,
  input  logic             stp,
  input  logic [7:0]       bus_in,
  output logic [7:0]       bus_out,
  output logic [7:0]       bus_oe,
  output logic             line_tx_en,
  output logic             line_tx_dat,
  output logic             line_tx_se0,
  input  logic             line_rx_dp,
  input  logic             line_rx_dm,
  input  logic             line_rx_rcv,
  input  logic [EVT_W-1:0] irq_evt,
  input  logic [EVT_W-1:0] irq_mask,
  input  logic             irq_clr,
  output logic             clk_run
);

  sm_mode_e mode_q;
  logic     exit_evt;
  logic     irq_q;

  ulpi_sm_mode_ctrl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_six      (cfg_six),
    .cfg_three    (cfg_three),
    .cfg_sleep    (cfg_sleep),
    .cfg_clk_keep (cfg_clk_keep),
    .stp          (stp),
    .mode_q       (mode_q),
    .exit_evt     (exit_evt),
    .clk_run      (clk_run)
  );

  ulpi_sm_irq_latch #(.EVT_W(EVT_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (irq_evt),
    .mask  (irq_mask),
    .clr   (irq_clr),
    .flush (exit_evt),
    .irq_q (irq_q)
  );

  ulpi_sm_pin_map u_map (
    .mode    (mode_q),
    .bus_in  (bus_in),
    .irq     (irq_q),
    .rx_dp   (line_rx_dp),
    .rx_dm   (line_rx_dm),
    .rx_rcv  (line_rx_rcv),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .tx_en   (line_tx_en),
    .tx_dat  (line_tx_dat),
    .tx_se0  (line_tx_se0)
  );

endmodule

// File: rtl/ulpi_sm_checker.sv
module ulpi_sm_checker
  import ulpi_sm_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stp,
  input logic [1:0]       mode,
  input logic             irq,
  input logic [EVT_W-1:0] irq_evt,
  input logic [EVT_W-1:0] irq_mask,
  input logic             irq_clr,
  input logic [7:0]       bus_out,
  input logic [7:0]       bus_oe,
  input logic             tx_en,
  input logic             tx_dat,
  input logic             tx_se0
);

  logic hit;
  assign hit = |(irq_evt & ~irq_mask);

  AST_STP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_NORMAL && stp && !hit) |=> (mode == MODE_NORMAL && !irq)); // R6

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NORMAL) |-> (bus_oe == 8'h00 && bus_out == 8'h00)); // R11

  AST_SER6_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SER6) |-> (bus_oe == 8'hF8 && !bus_out[7])); // R3

  AST_SER6_OE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SER6 && $past(mode) == MODE_SER6) |-> $stable(bus_oe)); // R3

  AST_SER3_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SER3) |-> (bus_oe[7:3] == 5'h1F && bus_out[7:4] == 4'h0 && !bus_oe[0])); // R4

  AST_LOWPWR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOWPWR) |-> (bus_oe == 8'hFF && (bus_out & 8'hF7) == 8'h00)); // R5

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && !(stp && mode != MODE_NORMAL)) |=> irq); // R8

  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!tx_dat && !tx_se0)); // R10

endmodule

bind ulpi_serial_mux ulpi_sm_checker #(.EVT_W(EVT_W)) u_sm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stp      (stp),
  .mode     (mode_q),
  .irq      (irq_q),
  .irq_evt  (irq_evt),
  .irq_mask (irq_mask),
  .irq_clr  (irq_clr),
  .bus_out  (bus_out),
  .bus_oe   (bus_oe),
  .tx_en    (line_tx_en),
  .tx_dat   (line_tx_dat),
  .tx_se0   (line_tx_se0)
);

// File: tb/test_ulpi_serial_mux.sv
module test_ulpi_serial_mux;

  localparam int EVT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0, cfg_six = 1'b0, cfg_three = 1'b0;
  logic             cfg_sleep = 1'b0, cfg_clk_keep = 1'b0;
  logic             stp = 1'b0;
  logic [7:0]       bus_in = 8'h00;
  logic [7:0]       bus_out, bus_oe;
  logic             line_tx_en, line_tx_dat, line_tx_se0;
  logic             line_rx_dp = 1'b0, line_rx_dm = 1'b0, line_rx_rcv = 1'b0;
  logic [EVT_W-1:0] irq_evt = '0, irq_mask = '0;
  logic             irq_clr = 1'b0;
  logic             clk_run;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  ulpi_serial_mux #(.EVT_W(EVT_W)) i_ulpi_serial_mux (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_six(cfg_six),
    .cfg_three(cfg_three), .cfg_sleep(cfg_sleep), .cfg_clk_keep(cfg_clk_keep),
    .stp(stp), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .line_tx_en(line_tx_en), .line_tx_dat(line_tx_dat), .line_tx_se0(line_tx_se0),
    .line_rx_dp(line_rx_dp), .line_rx_dm(line_rx_dm), .line_rx_rcv(line_rx_rcv),
    .irq_evt(irq_evt), .irq_mask(irq_mask), .irq_clr(irq_clr), .clk_run(clk_run)
  );

  // vector: mode[31:30] (1 six,2 three,3 low-power), bus_in[29:22],
  // rx {dp,dm,rcv}[21:19], exp_out[18:11], exp_oe[10:3], exp {en,dat,se0}[2:0]
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {2'd1, 8'h07, 3'b101, 8'h50, 8'hF8, 3'b111},
    {2'd1, 8'h02, 3'b010, 8'h20, 8'hF8, 3'b000},
    {2'd1, 8'hF9, 3'b000, 8'h00, 8'hF8, 3'b100},
    {2'd2, 8'h01, 3'b101, 8'h00, 8'hF8, 3'b100},
    {2'd2, 8'h00, 3'b101, 8'h02, 8'hFE, 3'b000},
    {2'd2, 8'h00, 3'b000, 8'h04, 8'hFE, 3'b000},
    {2'd2, 8'h07, 3'b000, 8'h00, 8'hF8, 3'b111},
    {2'd3, 8'hFF, 3'b111, 8'h00, 8'hFF, 3'b000}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic six, input logic three, input logic slp, input logic keep);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_six = six; cfg_three = three; cfg_sleep = slp; cfg_clk_keep = keep;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_six = 1'b0; cfg_three = 1'b0; cfg_sleep = 1'b0;
  endtask

  task automatic pulse_stp();
    @(negedge clk); stp = 1'b1;
    @(negedge clk); stp = 1'b0;
  endtask

  task automatic pulse_evt(input logic [EVT_W-1:0] e, input logic clr);
    @(negedge clk); irq_evt = e; irq_clr = clr;
    @(negedge clk); irq_evt = '0; irq_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", bus_oe, 8'h00);
    chk("R1 out", bus_out, 8'h00);
    chk("R1 tx", {5'd0, line_tx_en, line_tx_dat, line_tx_se0}, 8'h00);
    chk("R1 clk_run", {7'd0, clk_run}, 8'h01);

    // table walk: R3 R4 R5 R10 maps
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m;
      string tag;
      m = VEC[v][31:30];
      tag = (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R5";
      pulse_stp();
      bus_in = VEC[v][29:22];
      {line_rx_dp, line_rx_dm, line_rx_rcv} = VEC[v][21:19];
      cfg_write(m == 2'd1, m == 2'd2, m == 2'd3, 1'b1);
      chk({tag, " out"}, bus_out, VEC[v][18:11]);
      chk({tag, " oe"}, bus_oe, VEC[v][10:3]);
      chk({tag, " R10 tx"}, {5'd0, line_tx_en, line_tx_dat, line_tx_se0}, {5'd0, VEC[v][2:0]});
    end

    bus_in = 8'h00;
    {line_rx_dp, line_rx_dm, line_rx_rcv} = 3'b000;
    pulse_stp();
    chk("R6 exit to normal", bus_oe, 8'h00);
    chk("R11 normal out", bus_out, 8'h00);
    pulse_stp();
    chk("R6 stp in normal", bus_oe, 8'h00);

    // R9 clock keep uses value held before the entering write
    cfg_write(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 no mode bits", bus_oe, 8'h00);
    cfg_write(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9 clk stop", {7'd0, clk_run}, 8'h00);
    pulse_stp();
    chk("R9 clk normal", {7'd0, clk_run}, 8'h01);
    cfg_write(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 clk keep", {7'd0, clk_run}, 8'h01);

    // R7 write ignored while in six-wire map
    cfg_write(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 write ignored", bus_oe, 8'hF8);

    // R8 interrupt latch
    pulse_evt(4'b0100, 1'b0);
    chk("R8 irq set", bus_out & 8'h08, 8'h08);
    repeat (4) @(negedge clk);
    chk("R8 irq held", bus_out & 8'h08, 8'h08);
    pulse_evt(4'b0000, 1'b1);
    chk("R8 irq cleared", bus_out & 8'h08, 8'h00);
    irq_mask = 4'b0010;
    pulse_evt(4'b0010, 1'b0);
    chk("R8 masked event", bus_out & 8'h08, 8'h00);
    irq_mask = 4'b0000;
    pulse_evt(4'b0001, 1'b1);
    chk("R8 set beats clear", bus_out & 8'h08, 8'h08);

    // R6 exit clears the flag
    pulse_stp();
    cfg_write(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 flag cleared by exit", bus_out, 8'h00);
    chk("R5 low-power oe", bus_oe, 8'hFF);

    // R2 priority
    pulse_stp();
    cfg_write(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R2 six wins", bus_oe, 8'hF8);
    pulse_stp();
    cfg_write(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R2 three over sleep", bus_oe, 8'hFE);

    // R8 event in normal map shows after entry
    pulse_stp();
    pulse_evt(4'b1000, 1'b0);
    chk("R11 normal hides flag", bus_out, 8'h00);
    cfg_write(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8 R4 flag on DATA3", bus_out & 8'h08, 8'h08);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule